// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This unit sits between a core's execution side and a simple memory read port. It reads instruction bytes ahead of need into a small byte FIFO, so that bus traffic overlaps execution. The execution side drains the FIFO one byte per handshake. A taken jump is reported through the flush input together with the new target address. The flush throws away everything queued and any fetch still on the bus, and fetching starts again from the target.

The execution side can also ask for an operand read. The memory port is shared, so an operand request takes the bus before any prefetch once the bus is free. Its data is returned in the same cycle that memory completes it. The bus width is a parameter of 8 or 16 bits, and the queue depth follows from it: 6 bytes on a 16-bit bus and 4 on an 8-bit bus.

Two streams use valid/ready. On the consumer side, a byte moves when `cons_valid` and `cons_ready` are both high, and `cons_data` is stable while `cons_valid` is high and `cons_ready` is low. On the operand side, `op_valid` and `op_addr` must be held until `op_ready` pulses. The memory port is a request/ready pair. The unit keeps `mem_req` high with a stable `mem_addr` until `mem_rdy`, and memory data is taken in the cycle where both are high. Flush and its address are plain control pins.

Top module: `pfq_unit`

## Requirements
- R1: After reset the queue is empty (`cons_valid` low). The first prefetch request appears one cycle after reset is released, at address `RESET_ADDR`.
- R2: The queue holds at most 6 bytes with `BUS_W`=16 and 4 bytes with `BUS_W`=8. With the consumer stalled, exactly that many bytes can be drained afterwards.
- R3: Bytes reach the consumer in the order of their addresses within a straight run of fetches.
- R4: A 16-bit fetch reads two bytes, and the pointer advances by 2, only when the fetch pointer is even and at least 2 slots are free. Otherwise one byte is read and the pointer advances by 1. The byte is taken from bits 15:8 when the address is odd and from bits 7:0 when it is even.
- R5: `mem_req` stays high with a stable `mem_addr` until `mem_rdy`. Data is taken in the cycle where `mem_req` and `mem_rdy` are both high. `mem_req` is low for at least one cycle after every completed transfer.
- R6: A flush empties the queue, so `cons_valid` is low in the next cycle, and a pop in the flush cycle has no effect. The next prefetch is issued at `flush_addr`.
- R7: A fetch that is outstanding when a flush arrives, or that completes in the flush cycle, is discarded and never reaches the consumer.
- R8: When the bus is idle and `op_valid` is high, the operand read is issued ahead of any prefetch. `op_ready` is high in its completion cycle, with `op_rdata` equal to `mem_rdata`.
- R9: `cons_valid` is low exactly when the queue is empty. A byte leaves the queue only on `cons_valid && cons_ready`.
- R10: Prefetching continues while the consumer does not pop, until the queue is full. No new prefetch request is issued while the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_rdy | input | 1 | Memory completes the read this cycle |
| mem_rdata | input | BUS_W | Read data; on a 16-bit bus, the aligned word containing `mem_addr` |
| cons_valid | output | 1 | A queued byte is available |
| cons_ready | input | 1 | Consumer takes the byte |
| cons_data | output | 8 | Oldest queued byte |
| flush | input | 1 | Discard queue and restart fetching |
| flush_addr | input | ADDR_W | New fetch address used with `flush` |
| op_valid | input | 1 | Operand read request |
| op_addr | input | ADDR_W | Operand byte address |
| op_ready | output | 1 | Operand read completes this cycle |
| op_rdata | output | BUS_W | Operand read data |

## Verification
The main fill-and-drain behaviour is tried with three kinds of stimulus. A consumer that never pops shows where the fill stops and how large the queue really is. Flushes to odd and even targets with an always-ready memory separate the word-sized fetches from the byte-sized ones and show the lane selection. Random memory stalls, consumer stalls, flushes and operand requests, checked every cycle against a behavioural model, show whether the arbitration order, the discarding of stale fetches and the byte order hold up when these events collide in the same cycles.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  // Owner of the current memory transaction.
  typedef enum logic {
    OWN_FETCH   = 1'b0,
    OWN_OPERAND = 1'b1
  } bus_owner_e;

  // Queue depth is tied to the width of the memory port.
  function automatic int queue_depth(input int bus_w);
    return (bus_w == 16) ? 6 : 4;
  endfunction

endpackage

// File: rtl/pfq_byte_fifo.sv
module pfq_byte_fifo #(
  parameter int DEPTH = 6,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          pop,
  input  logic [1:0]    push_cnt,
  input  logic [7:0]    push_b0,
  input  logic [7:0]    push_b1,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic [CW-1:0] count
);

  logic [7:0]    slot [DEPTH];
  logic [IW-1:0] rd_q, wr_q, wr_nx1, wr_nx2;
  logic [CW-1:0] cnt_q, cnt_d;

  // Circular index advance for a depth that need not be a power of two.
  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wr_nx1 = nxt(wr_q);
  assign wr_nx2 = nxt(wr_nx1);

  always_comb begin
    cnt_d = cnt_q;
    if (pop) cnt_d = cnt_d - 1'b1;
    cnt_d = cnt_d + CW'(push_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (pop) rd_q <= nxt(rd_q);
      if (push_cnt == 2'd1)      wr_q <= wr_nx1;
      else if (push_cnt == 2'd2) wr_q <= wr_nx2;
      cnt_q <= cnt_d;
    end
  end

  // Storage: byte 0 lands at the write index, byte 1 right after it.
  always_ff @(posedge clk) begin
    if (!clr) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push_cnt != 2'd0 && wr_q == IW'(i))
          slot[i] <= push_b0;
        else if (push_cnt == 2'd2 && wr_nx1 == IW'(i))
          slot[i] <= push_b1;
      end
    end
  end

  assign out_valid = (cnt_q != '0);
  assign out_data  = slot[rd_q];
  assign count     = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (int'(cnt_q) + int'(push_cnt) - int'(pop)) <= DEPTH); // R2

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !out_valid); // R6

endmodule

// File: rtl/pfq_fetch_ptr.sv
module pfq_fetch_ptr #(
  parameter int BUS_W = 16,
  parameter int ADDR_W = 20,
  parameter int DEPTH = 6,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flush_addr,
  input  logic [CW-1:0]     q_free,
  input  logic              accept,
  input  logic              take_wide,
  input  logic [BUS_W-1:0]  rdata,
  output logic [ADDR_W-1:0] fptr,
  output logic              want_wide,
  output logic              can_fetch,
  output logic [1:0]        push_cnt,
  output logic [7:0]        push_b0,
  output logic [7:0]        push_b1
);

  logic [ADDR_W-1:0] fptr_q;
  logic [ADDR_W-1:0] adv;

  assign adv       = take_wide ? ADDR_W'(2) : ADDR_W'(1);
  assign can_fetch = (q_free != '0);
  assign push_cnt  = !accept ? 2'd0 : (take_wide ? 2'd2 : 2'd1);
  assign fptr      = fptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fptr_q <= RESET_ADDR;
    else if (flush)  fptr_q <= flush_addr;
    else if (accept) fptr_q <= fptr_q + adv;
  end

  generate
    if (BUS_W == 16) begin : g_word_bus
      assign want_wide = !fptr_q[0] && (q_free >= CW'(2));

      always_comb begin
        push_b1 = rdata[BUS_W-1 -: 8];
        if (take_wide)      push_b0 = rdata[7:0];
        else if (fptr_q[0]) push_b0 = rdata[BUS_W-1 -: 8];
        else                push_b0 = rdata[7:0];
      end

      AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (push_cnt == 2'd2) |-> !fptr_q[0]); // R4
    end else begin : g_byte_bus
      assign want_wide = 1'b0;
      assign push_b0   = rdata[7:0];
      assign push_b1   = rdata[7:0];
    end
  endgenerate

  AST_PTR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fptr_q == $past(flush_addr))); // R6

endmodule

// File: rtl/pfq_bus_arb.sv
module pfq_bus_arb #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              op_valid,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              mem_rdy,
  input  logic [ADDR_W-1:0] fptr,
  input  logic              can_fetch,
  input  logic              want_wide,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              op_ready,
  output logic              accept,
  output logic              take_wide
);
  import pfq_pkg::*;

  logic              act_q;
  bus_owner_e        own_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wide_q;
  logic              drop_q;
  logic              done;

  assign done = act_q && mem_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      own_q  <= OWN_FETCH;
      addr_q <= '0;
      wide_q <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      // A fetch overtaken by a flush is marked stale until memory answers.
      if (done)
        drop_q <= 1'b0;
      else if (flush && act_q && own_q == OWN_FETCH)
        drop_q <= 1'b1;

      if (act_q) begin
        if (mem_rdy) act_q <= 1'b0;
      end else if (op_valid) begin
        act_q  <= 1'b1;
        own_q  <= OWN_OPERAND;
        addr_q <= op_addr;
        wide_q <= 1'b0;
      end else if (!flush && can_fetch) begin
        act_q  <= 1'b1;
        own_q  <= OWN_FETCH;
        addr_q <= fptr;
        wide_q <= want_wide;
      end
    end
  end

  assign mem_req   = act_q;
  assign mem_addr  = addr_q;
  assign op_ready  = done && (own_q == OWN_OPERAND);
  assign accept    = done && (own_q == OWN_FETCH) && !drop_q && !flush;
  assign take_wide = wide_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr))); // R5

  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rdy) |=> !mem_req); // R5

  AST_OP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && op_valid) |=> (mem_req && mem_addr == $past(op_addr))); // R8

  AST_STALE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && mem_req && !mem_rdy && own_q == OWN_FETCH) |=> !accept); // R7

endmodule

// File: rtl/pfq_unit.sv
module pfq_unit #(
  parameter int BUS_W = 16,
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 20'h0FFF0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rdy,
  input  logic [BUS_W-1:0]  mem_rdata,
  output logic              cons_valid,
  input  logic              cons_ready,
  output logic [7:0]        cons_data,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flush_addr,
  input  logic              op_valid,
  input  logic [ADDR_W-1:0] op_addr,
  output logic              op_ready,
  output logic [BUS_W-1:0]  op_rdata
);

  localparam int DEPTH = pfq_pkg::queue_depth(BUS_W);
  localparam int CW    = $clog2(DEPTH + 1);

  logic [CW-1:0]     q_count, q_free;
  logic              pop;
  logic              accept, take_wide, want_wide, can_fetch;
  logic [ADDR_W-1:0] fptr;
  logic [1:0]        push_cnt;
  logic [7:0]        push_b0, push_b1;

  assign q_free   = CW'(DEPTH) - q_count;
  assign pop      = cons_valid && cons_ready && !flush;
  assign op_rdata = mem_rdata;

  pfq_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (flush),
    .pop       (pop),
    .push_cnt  (push_cnt),
    .push_b0   (push_b0),
    .push_b1   (push_b1),
    .out_valid (cons_valid),
    .out_data  (cons_data),
    .count     (q_count)
  );

  pfq_fetch_ptr #(
    .BUS_W      (BUS_W),
    .ADDR_W     (ADDR_W),
    .DEPTH      (DEPTH),
    .RESET_ADDR (RESET_ADDR)
  ) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .flush_addr (flush_addr),
    .q_free     (q_free),
    .accept     (accept),
    .take_wide  (take_wide),
    .rdata      (mem_rdata),
    .fptr       (fptr),
    .want_wide  (want_wide),
    .can_fetch  (can_fetch),
    .push_cnt   (push_cnt),
    .push_b0    (push_b0),
    .push_b1    (push_b1)
  );

  pfq_bus_arb #(.ADDR_W(ADDR_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .op_valid  (op_valid),
    .op_addr   (op_addr),
    .mem_rdy   (mem_rdy),
    .fptr      (fptr),
    .can_fetch (can_fetch),
    .want_wide (want_wide),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .op_ready  (op_ready),
    .accept    (accept),
    .take_wide (take_wide)
  );

  AST_FULL_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && !op_valid && q_count == CW'(DEPTH)) |=> !mem_req); // R10

endmodule

// File: tb/tb_pfq_unit.sv
`timescale 1ns/1ps
module tb_pfq_unit;
  localparam int BW  = 16;
  localparam int AW  = 20;
  localparam int DEP = 6;
  localparam logic [AW-1:0] RST = 20'h0FFF0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mem_req, mem_rdy = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [BW-1:0] mem_rdata = '0;
  logic          cons_valid, cons_ready = 1'b0;
  logic [7:0]    cons_data;
  logic          flush = 1'b0;
  logic [AW-1:0] flush_addr = '0;
  logic          op_valid = 1'b0;
  logic [AW-1:0] op_addr = '0;
  logic          op_ready;
  logic [BW-1:0] op_rdata;

  always #10 clk = ~clk;

  pfq_unit #(.BUS_W(BW), .ADDR_W(AW), .RESET_ADDR(RST)) dut (
    .clk(clk), .rst_n(rst_n),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdy(mem_rdy), .mem_rdata(mem_rdata),
    .cons_valid(cons_valid), .cons_ready(cons_ready), .cons_data(cons_data),
    .flush(flush), .flush_addr(flush_addr),
    .op_valid(op_valid), .op_addr(op_addr), .op_ready(op_ready), .op_rdata(op_rdata)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // Stimulus for the next cycle
  bit            s_flush = 0, s_opv = 0, s_cready = 0, s_rdy = 0;
  logic [AW-1:0] s_faddr = '0, s_oaddr = '0;
  bit            op_seen = 0;

  // Behavioural reference state
  logic [7:0]    mq[$];
  logic [AW-1:0] m_fptr = RST, m_baddr = '0;
  bit            m_act = 0, m_isop = 0, m_wide = 0, m_drop = 0;

  function automatic logic [7:0] bval(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h5};
  endfunction

  function automatic logic [15:0] word(input logic [AW-1:0] a);
    return {bval(a | 20'h1), bval(a & ~20'h1)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic step();
    bit done, acc, exp_opr;
    int cnt;
    logic [15:0] w;
    logic [AW-1:0] nf;
    @(negedge clk);
    rst_n      = 1'b1;
    flush      = s_flush;
    flush_addr = s_faddr;
    op_valid   = s_opv;
    op_addr    = s_oaddr;
    cons_ready = s_cready;
    mem_rdy    = s_rdy;
    mem_rdata  = word(mem_addr);
    #1;
    exp_opr = m_act && m_isop && mem_rdy;
    chk(mem_req === m_act, "R5", "mem_req", 32'(mem_req), 32'(m_act));
    if (m_act) chk(mem_addr === m_baddr, "R5", "mem_addr", 32'(mem_addr), 32'(m_baddr));
    chk(cons_valid === (mq.size() > 0), "R9", "cons_valid", 32'(cons_valid), 32'(mq.size() > 0));
    if (mq.size() > 0) chk(cons_data === mq[0], "R3", "cons_data", 32'(cons_data), 32'(mq[0]));
    chk(op_ready === exp_opr, "R8", "op_ready", 32'(op_ready), 32'(exp_opr));
    if (exp_opr) chk(op_rdata === word(m_baddr), "R8", "op_rdata", 32'(op_rdata), 32'(word(m_baddr)));
    op_seen = exp_opr;

    // Model next state from the inputs applied in this cycle
    done = m_act && mem_rdy;
    cnt  = mq.size();
    w    = word(m_baddr);
    acc  = done && !m_isop && !m_drop && !flush;
    if (flush) mq.delete();
    else begin
      if (cnt > 0 && cons_ready) mq.delete(0);
      if (acc) begin
        if (m_wide) begin mq.push_back(w[7:0]); mq.push_back(w[15:8]); end
        else mq.push_back(m_baddr[0] ? w[15:8] : w[7:0]);
      end
    end
    nf = m_fptr;
    if (flush) nf = flush_addr;
    else if (acc) nf = m_fptr + (m_wide ? 20'd2 : 20'd1);
    if (done) m_drop = 0;
    else if (flush && m_act && !m_isop) m_drop = 1;
    if (m_act) begin
      if (mem_rdy) m_act = 0;
    end else if (op_valid) begin
      m_act = 1; m_isop = 1; m_baddr = op_addr; m_wide = 0;
    end else if (!flush && cnt < DEP) begin
      m_act = 1; m_isop = 0; m_baddr = m_fptr;
      m_wide = (m_fptr[0] == 1'b0) && (DEP - cnt >= 2);
    end
    m_fptr = nf;
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk);

    // R1: reset state, then first request at the reset address
    s_rdy = 0;
    step();
    chk(!mem_req && !cons_valid, "R1", "idle after reset", {mem_req, cons_valid}, 0);
    step();
    chk(mem_req && mem_addr == RST, "R1", "first fetch addr", 32'(mem_addr), 32'(RST));

    // R4/R6: flush to an odd target, byte fetch then word fetches
    s_cready = 0; s_rdy = 1; s_flush = 1; s_faddr = 20'h00203;
    step();
    s_flush = 0;
    step();
    chk(!cons_valid, "R6", "queue empty after flush", 32'(cons_valid), 0);
    step();
    chk(mem_req && mem_addr == 20'h00203, "R4", "odd fetch addr", 32'(mem_addr), 32'h203);
    step();
    chk(cons_valid && cons_data == bval(20'h00203), "R4", "upper lane byte", 32'(cons_data), 32'(bval(20'h00203)));
    step();
    chk(mem_req && mem_addr == 20'h00204, "R4", "realigned addr", 32'(mem_addr), 32'h204);
    step(); step();
    chk(mem_req && mem_addr == 20'h00206, "R4", "word step of 2", 32'(mem_addr), 32'h206);

    // R10/R2: stalled consumer, fill stops at full depth
    repeat (20) step();
    chk(!mem_req, "R10", "no fetch when full", 32'(mem_req), 0);
    s_rdy = 0; s_cready = 1; n = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (cons_valid) n++;
    end
    chk(n == DEP, "R2", "bytes held", 32'(n), 32'(DEP));

    // R7: outstanding fetch overtaken by a flush is discarded
    s_cready = 0; s_flush = 1; s_faddr = 20'h00400;
    step();
    s_flush = 0; s_rdy = 1;
    step();
    step();
    chk(!cons_valid, "R7", "stale data dropped", 32'(cons_valid), 0);
    step();
    chk(mem_req && mem_addr == 20'h00400, "R7", "refetch at target", 32'(mem_addr), 32'h400);
    step();
    chk(cons_valid && cons_data == bval(20'h00400), "R7", "first byte from target", 32'(cons_data), 32'(bval(20'h00400)));

    // R8: operand read wins over prefetch on an idle bus
    s_flush = 1; s_faddr = 20'h00500;
    step();
    s_flush = 0; s_opv = 1; s_oaddr = 20'h12345;
    step();
    step();
    chk(mem_req && mem_addr == 20'h12345 && op_ready, "R8", "operand first", 32'(mem_addr), 32'h12345);
    chk(op_rdata == word(20'h12345), "R8", "operand data", 32'(op_rdata), 32'(word(20'h12345)));
    s_opv = 0;

    // Random mix checked every cycle against the model
    for (int i = 0; i < 3000; i++) begin
      s_rdy    = ($urandom % 3) != 0;
      s_cready = ($urandom % 2) != 0;
      s_flush  = ($urandom % 40) == 0;
      s_faddr  = AW'($urandom);
      if (!s_opv && ($urandom % 25) == 0) begin
        s_opv   = 1;
        s_oaddr = AW'($urandom);
      end
      step();
      if (op_seen) s_opv = 0;
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule